// File: doc/BRIEF.md
# Radix-4 Booth Multiplier, 16 x 16

This block multiplies a 16-bit multiplicand by a 16-bit multiplier and returns the 32-bit product. A mode input selects two's-complement or unsigned operands. The multiplier is recoded in radix 4, so each overlapping three-bit slice of it picks one partial product out of zero, plus or minus the multiplicand, and plus or minus twice the multiplicand. This gives nine rows instead of sixteen.

Negative rows are built by inverting the selected multiple. The missing +1 goes into a separate correction row. Sign extension of every row is replaced by two things: the inverted sign bit placed just above each row, and a single constant computed at elaboration time. The rows pass through a chain of carry-save compressors and then one carry-propagate adder.

The result is captured in an output register when the start strobe is high. A done pulse follows one cycle later. A host drives the operands and the mode together with start, and reads the product in the cycle where done is high.

Top module: `booth_mul16`

## Requirements
- R1: With unsigned mode (signed_mode = 0), the product equals the unsigned 32-bit product of the two operands.
- R2: With signed mode (signed_mode = 1), the product equals the 32-bit two's-complement product of the two operands.
- R3: Each multiplier group (x[2i+1], x[2i], x[2i-1]), with x[-1] = 0, selects a multiple as follows: 000 and 111 select 0; 001 and 010 select +Y; 011 selects +2Y; 100 selects -2Y; 101 and 110 select -Y. The single and double selects are never both active.
- R4: In unsigned mode the multiplier is zero-extended with x16 = x17 = 0, which gives nine rows. In signed mode the multiplier is sign-extended and the ninth row is forced to zero. Multipliers with bit 15 set are therefore correct in both modes.
- R5: A start in cycle n loads the product register and raises done for exactly cycle n+1. Done is low in every cycle that does not follow a start.
- R6: While start is low, the product output holds its value, whatever the operands and mode do.
- R7: The corner cases are exact: 0x8000 x 0x8000 signed gives 0x40000000, 0xFFFF x 0xFFFF unsigned gives 0xFFFE0001, and 0xFFFF x 0xFFFF signed gives 1.
- R8: While rst_n is low, product is 0 and done is 0.
- R9: The rows, the correction row and the constant in carry-save form sum to the same value modulo 2^32 at every compressor stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Load strobe: capture the product of the present operands |
| signed_mode | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| mcand | input | 16 | Multiplicand Y |
| mplier | input | 16 | Multiplier X |
| product | output | 32 | Registered product |
| done | output | 1 | One-cycle pulse marking a new product |

## Verification
The only registered results are product and done. Both are due on the first rising edge after the edge at which start is sampled. The bench drives start and the operands on falling edges and checks product and done on the next falling edge. In the following idle cycle it scrambles the operands and the mode, then checks that done has dropped and the product has not moved. Expected products come from plain widened integer multiplication in the bench, over a grid of boundary values and pseudo-random values in both modes.

// File: rtl/booth_mul_pkg.sv
package booth_mul_pkg;

  // Row controls for one radix-4 group
  typedef struct packed {
    logic single;
    logic dbl;
    logic neg;
  } booth_ctl_t;

  // Recode one group {x(2i+1), x(2i), x(2i-1)}
  function automatic booth_ctl_t booth_encode(input logic [2:0] g);
    booth_ctl_t c;
    c.single = g[1] ^ g[0];
    c.dbl    = (g[2] & ~g[1] & ~g[0]) | (~g[2] & g[1] & g[0]);
    c.neg    = g[2];
    return c;
  endfunction

  // Constant that replaces sign extension: each row i carries its inverted
  // sign at column (w+1+2i), which adds 2^(w+1+2i) too much; subtract that.
  function automatic logic [63:0] sext_const(input int w, input int rows);
    logic [63:0] k;
    k = '0;
    for (int i = 0; i < rows; i++) begin
      k = k - (64'd1 << (w + 1 + 2 * i));
    end
    return k;
  endfunction

endpackage

// File: rtl/booth_pp_row.sv
module booth_pp_row
  import booth_mul_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W:0]   mcand_ext,  // multiplicand, extended by one bit
  input  logic [2:0]   grp,        // multiplier group
  output logic [W+1:0] row_bits,   // {~sign, pp[W:0]}
  output logic         neg         // +1 owed at the row's LSB column
);
  localparam int PPW = W + 2;

  booth_ctl_t ctl;
  logic [PPW:0]   yx;   // yx[j+1] = y(j), yx[0] = y(-1) = 0
  logic [PPW-1:0] pp;

  assign ctl = booth_encode(grp);
  assign yx  = {mcand_ext[W], mcand_ext, 1'b0};

  // Per-bit selector: single picks y(j), double picks y(j-1)
  for (genvar j = 0; j < PPW; j++) begin : g_sel
    assign pp[j] = ((ctl.single & yx[j+1]) | (ctl.dbl & yx[j])) ^ ctl.neg;
  end

  assign row_bits = {~pp[PPW-1], pp[PPW-2:0]};
  assign neg      = ctl.neg;

  // R3: single and double never both active
  always_comb begin
    p_sel_exclusive_r3: assert (!(ctl.single && ctl.dbl))
      else $error("single and double both set");
  end

  // R3: groups 000 and 111 select a zero multiple
  always_comb begin
    if (grp == 3'b000 || grp == 3'b111) begin
      p_zero_group_r3: assert (pp == {PPW{ctl.neg}})
        else $error("zero group produced non-zero row");
    end
  end

endmodule

// File: rtl/booth_csa.sv
module booth_csa #(
  parameter int N = 32
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic [N-1:0] c,
  output logic [N-1:0] s,
  output logic [N-1:0] co   // carries, already moved up one column
);
  assign s = a ^ b ^ c;

  assign co[0] = 1'b0;
  for (genvar j = 0; j < N - 1; j++) begin : g_maj
    assign co[j+1] = (a[j] & b[j]) | (a[j] & c[j]) | (b[j] & c[j]);
  end

  // R9: a 3:2 stage keeps the total modulo 2^N
  always_comb begin
    p_csa_conserve_r9: assert (N'(s + co) == N'(a + b + c))
      else $error("carry-save stage lost value");
  end

endmodule

// File: rtl/booth_mul16.sv
module booth_mul16
  import booth_mul_pkg::*;
#(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           signed_mode,
  input  logic [W-1:0]   mcand,
  input  logic [W-1:0]   mplier,
  output logic [2*W-1:0] product,
  output logic           done
);
  localparam int PW    = 2 * W;
  localparam int NPP   = W / 2 + 1;   // Booth rows
  localparam int NROWS = NPP + 1;     // plus the correction row
  localparam int NCSA  = NROWS - 2;
  localparam logic [63:0] KFULL = sext_const(W, NPP);
  localparam logic [PW-1:0] KSEXT = KFULL[PW-1:0];

  logic           ext_y, ext_x;
  logic [W:0]     mcand_ext;
  logic [W+2:0]   xe;                 // {x17, x16, x[15:0], x(-1)}
  logic [NPP-1:0] neg_v;
  logic [PW-1:0]  rows_v [NROWS];
  logic [PW-1:0]  acc_s  [NCSA+1];
  logic [PW-1:0]  acc_c  [NCSA+1];
  logic [PW-1:0]  corr_row;
  logic [PW-1:0]  prod_next;

  assign ext_y     = signed_mode & mcand[W-1];
  assign ext_x     = signed_mode & mplier[W-1];
  assign mcand_ext = {ext_y, mcand};
  assign xe        = {ext_x, ext_x, mplier, 1'b0};

  // Booth rows
  for (genvar i = 0; i < NPP; i++) begin : g_row
    logic [2:0]   grp;
    logic [W+1:0] rb;
    if (i == NPP - 1) begin : g_last
      // signed mode uses only W/2 rows
      assign grp = signed_mode ? 3'b000 : xe[2*i+2 : 2*i];
    end else begin : g_mid
      assign grp = xe[2*i+2 : 2*i];
    end
    booth_pp_row #(.W(W)) row_i (
      .mcand_ext (mcand_ext),
      .grp       (grp),
      .row_bits  (rb),
      .neg       (neg_v[i])
    );
    assign rows_v[i] = PW'(rb) << (2 * i);
  end

  // Correction row: negate carries at columns 2i, plus the sign constant
  always_comb begin
    corr_row = KSEXT;
    for (int i = 0; i < NPP; i++) begin
      corr_row[2*i] = corr_row[2*i] | neg_v[i];
    end
  end
  assign rows_v[NROWS-1] = corr_row;

  // Carry-save chain
  assign acc_s[0] = rows_v[0];
  assign acc_c[0] = rows_v[1];
  for (genvar k = 0; k < NCSA; k++) begin : g_csa
    booth_csa #(.N(PW)) csa_k (
      .a  (acc_s[k]),
      .b  (acc_c[k]),
      .c  (rows_v[k+2]),
      .s  (acc_s[k+1]),
      .co (acc_c[k+1])
    );
  end

  // Final carry-propagate adder
  assign prod_next = acc_s[NCSA] + acc_c[NCSA];

  // Output register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      product <= '0;
      done    <= 1'b0;
    end else begin
      done <= start;
      if (start) product <= prod_next;
    end
  end

  // R5: done follows start by one cycle
  p_done_after_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);
  // R5: no done without a start
  p_no_stray_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done);
  // R6: product holds while idle
  p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(product));
  // R8: reset state
  always_comb begin
    if (!rst_n) begin
      p_reset_clear_r8: assert (product == '0 && !done)
        else $error("outputs not clear in reset");
    end
  end

endmodule

// File: tb/booth_mul16_tb.sv
`timescale 1ns/1ps
module booth_mul16_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        signed_mode = 1'b0;
  logic [15:0] mcand = '0;
  logic [15:0] mplier = '0;
  logic [31:0] product;
  logic        done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [31:0] lcg = 32'h1234_5677;

  always #2.5 clk = ~clk;

  booth_mul16 #(.W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .signed_mode(signed_mode),
    .mcand(mcand), .mplier(mplier), .product(product), .done(done)
  );

  function automatic logic [31:0] ref_mul(input logic [15:0] a,
                                           input logic [15:0] b,
                                           input logic sm);
    logic [31:0] ea, eb;
    ea = sm ? {{16{a[15]}}, a} : {16'h0, a};
    eb = sm ? {{16{b[15]}}, b} : {16'h0, b};
    return ea * eb;
  endfunction

  task automatic check(input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] pick(input int k);
    case (k)
      0: return 16'h0000;  1: return 16'h0001;  2: return 16'hFFFF;
      3: return 16'h8000;  4: return 16'h7FFF;  5: return 16'h8001;
      6: return 16'h0002;  7: return 16'hAAAA;  8: return 16'h5555;
      9: return 16'h0003;  10: return 16'hFFFE; 11: return 16'h00FF;
      default: return 16'h0;
    endcase
  endfunction

  // Drive on falling edge, result due at the next falling edge (R5)
  task automatic do_mul(input logic [15:0] a, input logic [15:0] b,
                        input logic sm, input string tag);
    logic [31:0] exp;
    exp = ref_mul(a, b, sm);
    @(negedge clk);
    mcand = a; mplier = b; signed_mode = sm; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R5 done pulse", {31'b0, done}, 32'd1);
    check(tag, product, exp);
    // R6: scramble inputs without start; product must hold
    mcand = ~a; mplier = b ^ 16'h5A5A; signed_mode = ~sm;
    @(negedge clk);
    check("R5 done low", {31'b0, done}, 32'd0);
    check("R6 hold", product, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset product", product, 32'd0);
    check("R8 reset done", {31'b0, done}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R7 corners
    do_mul(16'h8000, 16'h8000, 1'b1, "R7 signed min*min");
    do_mul(16'hFFFF, 16'hFFFF, 1'b0, "R7 unsigned ones");
    do_mul(16'hFFFF, 16'hFFFF, 1'b1, "R7 signed -1*-1");
    do_mul(16'h0000, 16'hFFFF, 1'b1, "R7 zero");

    // R3: multipliers exercising each group code in the low group
    for (int b = 0; b < 8; b++) begin
      do_mul(16'h1234, 16'(b), 1'b0, "R3 group codes unsigned");
      do_mul(16'hC321, 16'(b), 1'b1, "R3 group codes signed");
    end

    // R4: multiplier top bit set needs the ninth row in unsigned mode
    do_mul(16'h7FFF, 16'h8000, 1'b0, "R4 x16 row unsigned");
    do_mul(16'hFFFF, 16'hC000, 1'b0, "R4 x16 row unsigned ones");
    do_mul(16'h7FFF, 16'h8000, 1'b1, "R4 eight rows signed");

    // Boundary grid in both modes (R1, R2)
    for (int i = 0; i < 12; i++) begin
      for (int j = 0; j < 12; j++) begin
        do_mul(pick(i), pick(j), 1'b0, "R1 grid");
        do_mul(pick(i), pick(j), 1'b1, "R2 grid");
      end
    end

    // Pseudo-random vectors in both modes (R1, R2, R9)
    for (int n = 0; n < 1500; n++) begin
      logic [15:0] a, b;
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      a = lcg[31:16];
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      b = lcg[31:16];
      do_mul(a, b, n[0], n[0] ? "R2 random R9" : "R1 random R9");
    end

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule